// File: doc/BRIEF.md
# Serial Register-Access Slave Port

This block is a serial slave that lets a host controller read and write a bank of byte-wide configuration registers. The host frames each access by holding the chip-select low. The first eight serial clock rising edges carry a command byte. That byte gives the access direction, a byte count from one to four, and a 5-bit start address. The data bytes follow. Each written byte lands in its register on the final bit of that byte, so registers change while the frame is still open. Read data is launched on serial clock falling edges, so the host can capture it on the next rising edge.

Register 0 holds the port configuration. Bit 6 selects the bit order of both the command and the data bytes. Bit 7 selects the pin mode. In single-data-pin mode, read data shares the input pin through an output enable. In separate-output mode, read data goes out on its own pin. A write to register 0 takes effect from the very next bit of the same frame. The address step direction follows the bit order: it counts down when the most significant bit is sent first and up when the least significant bit is sent first. Raising the chip-select abandons the frame at any point and discards a partly received byte. All register contents are also presented as one flat parallel bus for the surrounding logic. With fewer than 32 registers, addresses without a register read as zero and ignore writes.

Top module: `spi_reg_port`

## Requirements
- R1: After rst_n is released, every register reads 0x00 on regs_flat and both output enables are low. So the port starts in MSB-first order and single-data-pin mode.
- R2: The first eight SCLK rising edges after CSB falls form the command byte. Command bit 7 = 1 selects a read and 0 selects a write. Command bits 4:0 give the first register address.
- R3: Command bits 6:5 set the number of data bytes: 00 gives 1, 01 gives 3, 10 gives 2, 11 gives 4. Any further bits before CSB rises change no register.
- R4: A written byte appears on regs_flat (register n at bits 8n+7:8n) right after the rising edge that carries its eighth bit, while CSB is still low.
- R5: After each data byte the address moves by one: down in MSB-first order, up in LSB-first order, wrapping modulo 32. The direction is taken from the order in force on that byte's final bit.
- R6: Register 0 bit 6 = 0 sends each byte bit 7 first. Bit 6 = 1 sends bit 0 first. This applies to command bytes and to data bytes in both directions.
- R7: A write to register 0 changes the bit order and pin mode from the next bit of the same frame.
- R8: Each read data bit is driven on the SCLK falling edge before the rising edge at which the host samples it. The data bytes carry the addressed register contents in the current bit order.
- R9: With register 0 bit 7 = 0, sdio_oe is high only during the data phase of a read with CSB low, and sdo_oe stays low. With bit 7 = 1, sdo_oe takes that role and sdio_oe stays low.
- R10: Raising CSB mid-frame discards the partly received byte. Bytes completed earlier in that frame remain written. The next CSB low starts a new command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low asynchronous reset of the register bank |
| sclk | input | 1 | Serial clock from the host |
| csb | input | 1 | Active-low frame select; high resets the frame state |
| sdio_in | input | 1 | Serial data from the host |
| sdio_out | output | 1 | Read data for the shared data pin |
| sdio_oe | output | 1 | Drive enable of the shared data pin (single-pin mode) |
| sdo | output | 1 | Read data for the separate output pin |
| sdo_oe | output | 1 | Drive enable of the separate output pin |
| regs_flat | output | NREG*8 | All registers, register n at bits 8n+7:8n |

## Verification
Most internal faults in this block show up on regs_flat within one byte time. A bit counter or bit-position slip scrambles the byte written at the next eighth edge. A wrong address step puts the second byte of a multi-byte write in the wrong register at once. Phase or count errors show as a command treated as data, or as an extra write from the trailing byte sent after the counted ones. Faults on the read path show on the next rising-edge sample of a read byte, either as a wrong bit or as an enable that is high in the wrong mode or outside the read data phase.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;
   localparam int CMD_W   = 8;
   localparam int ADDR_W  = 5;
   localparam int ORD_BIT = 6;
   localparam int PIN_BIT = 7;

   typedef enum logic [1:0] {PH_CMD, PH_DATA, PH_DONE} phase_t;

   // count code -> number of bytes minus one (00:0, 01:2, 10:1, 11:3)
   function automatic logic [1:0] count_m1(input logic [1:0] code);
      return {code[0], code[1]};
   endfunction
endpackage

// File: rtl/spi_rf_ctrl.sv
module spi_rf_ctrl
   import spi_rf_pkg::*;
(
   input  logic              sclk,
   input  logic              csb,
   input  logic              sdio_in,
   input  logic              cfg_lsb,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [7:0]        wr_data,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [2:0]        bit_pos,
   output logic              rd_phase
);
   phase_t            phase_q;
   logic [2:0]        bit_q;
   logic [7:0]        asm_q;
   logic [7:0]        full_byte;
   logic              rw_q;
   logic [1:0]        left_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] addr_step;
   logic              last_bit;

   assign bit_pos  = cfg_lsb ? bit_q : (3'd7 - bit_q);
   assign last_bit = (bit_q == 3'd7);

   always_comb begin
      full_byte          = asm_q;
      full_byte[bit_pos] = sdio_in;
   end

   assign addr_step = cfg_lsb ? (addr_q + 5'd1) : (addr_q - 5'd1);
   assign wr_en     = (phase_q == PH_DATA) && !rw_q && last_bit;
   assign wr_addr   = addr_q;
   assign wr_data   = full_byte;
   assign cur_addr  = addr_q;
   assign rd_phase  = (phase_q == PH_DATA) && rw_q;

   always_ff @(posedge sclk or posedge csb) begin
      if (csb) begin
         phase_q <= PH_CMD;
         bit_q   <= 3'd0;
         asm_q   <= 8'h00;
         rw_q    <= 1'b0;
         left_q  <= 2'd0;
         addr_q  <= '0;
      end else if (phase_q != PH_DONE) begin
         asm_q <= full_byte;
         bit_q <= bit_q + 3'd1;
         if (last_bit) begin
            if (phase_q == PH_CMD) begin
               rw_q    <= full_byte[7];
               left_q  <= count_m1(full_byte[6:5]);
               addr_q  <= full_byte[ADDR_W-1:0];
               phase_q <= PH_DATA;
            end else begin
               addr_q <= addr_step;
               if (left_q == 2'd0) phase_q <= PH_DONE;
               else                left_q  <= left_q - 2'd1;
            end
         end
      end
   end

   // R2: eight command bits lead into the data phase
   p_cmd_len_r2: assert property (@(posedge sclk) disable iff (csb)
      (phase_q == PH_CMD && last_bit) |=> (phase_q == PH_DATA && bit_q == 3'd0));

   // R3: the last counted byte closes the frame
   p_count_end_r3: assert property (@(posedge sclk) disable iff (csb)
      (phase_q == PH_DATA && last_bit && left_q == 2'd0) |=> (phase_q == PH_DONE));

   // R5: address moves by one in the direction of the bit order
   p_addr_step_r5: assert property (@(posedge sclk) disable iff (csb)
      (phase_q == PH_DATA && last_bit) |=>
      (addr_q == ($past(cfg_lsb) ? ($past(addr_q) + 5'd1) : ($past(addr_q) - 5'd1))));
endmodule

// File: rtl/spi_rf_bank.sv
module spi_rf_bank
   import spi_rf_pkg::*;
#(
   parameter int NREG = 32
)(
   input  logic              rst_n,
   input  logic              sclk,
   input  logic              csb,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data,
   output logic              cfg_lsb,
   output logic              cfg_w4,
   output logic [NREG*8-1:0] regs_flat
);
   localparam int SPAN = 1 << ADDR_W;

   if (NREG < 2 || NREG > SPAN) begin : g_bad_nreg
      $error("spi_rf_bank: NREG must be within 2..32");
   end

   logic [7:0] regs [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge sclk or negedge rst_n) begin
         if (!rst_n)                                   regs[g] <= 8'h00;
         else if (wr_en && (int'(wr_addr) == g))       regs[g] <= wr_data;
      end
      assign regs_flat[g*8 +: 8] = regs[g];
   end

   always_comb begin
      rd_data = 8'h00;
      for (int i = 0; i < NREG; i++)
         if (int'(rd_addr) == i) rd_data = regs[i];
   end

   assign cfg_lsb = regs[0][ORD_BIT];
   assign cfg_w4  = regs[0][PIN_BIT];

   // R4: a finished byte is visible right after its last edge
   p_write_lands_r4: assert property (@(posedge sclk) disable iff (!rst_n || csb)
      (wr_en && int'(wr_addr) < NREG) |=> (regs_flat[8*$past(wr_addr) +: 8] == $past(wr_data)));
endmodule

// File: rtl/spi_rf_txout.sv
module spi_rf_txout (
   input  logic       sclk,
   input  logic       csb,
   input  logic       rd_phase,
   input  logic [7:0] rd_data,
   input  logic [2:0] bit_pos,
   input  logic       cfg_w4,
   output logic       sdio_out,
   output logic       sdio_oe,
   output logic       sdo,
   output logic       sdo_oe
);
   logic bit_q;
   logic oe_q;

   always_ff @(negedge sclk or posedge csb) begin
      if (csb) begin
         bit_q <= 1'b0;
         oe_q  <= 1'b0;
      end else begin
         bit_q <= rd_data[bit_pos];
         oe_q  <= rd_phase;
      end
   end

   assign sdio_out = bit_q;
   assign sdo      = bit_q;
   assign sdio_oe  = oe_q && !cfg_w4 && !csb;
   assign sdo_oe   = oe_q &&  cfg_w4 && !csb;

   // R9: a drive enable is only ever up inside a read data phase
   p_oe_in_read_r9: assert property (@(posedge sclk) disable iff (csb)
      (sdio_oe || sdo_oe) |-> rd_phase);

   // R9: never both pins driven
   p_one_pin_r9: assert property (@(posedge sclk) disable iff (csb)
      $onehot0({sdio_oe, sdo_oe}));
endmodule

// File: rtl/spi_reg_port.sv
module spi_reg_port
   import spi_rf_pkg::*;
#(
   parameter int NREG = 32
)(
   input  logic              rst_n,
   input  logic              sclk,
   input  logic              csb,
   input  logic              sdio_in,
   output logic              sdio_out,
   output logic              sdio_oe,
   output logic              sdo,
   output logic              sdo_oe,
   output logic [NREG*8-1:0] regs_flat
);
   logic              wr_en;
   logic [ADDR_W-1:0] wr_addr;
   logic [7:0]        wr_data;
   logic [ADDR_W-1:0] cur_addr;
   logic [2:0]        bit_pos;
   logic              rd_phase;
   logic [7:0]        rd_data;
   logic              cfg_lsb;
   logic              cfg_w4;

   spi_rf_ctrl u_ctrl (
      .sclk     (sclk),
      .csb      (csb),
      .sdio_in  (sdio_in),
      .cfg_lsb  (cfg_lsb),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .cur_addr (cur_addr),
      .bit_pos  (bit_pos),
      .rd_phase (rd_phase)
   );

   spi_rf_bank #(.NREG(NREG)) u_bank (
      .rst_n     (rst_n),
      .sclk      (sclk),
      .csb       (csb),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rd_addr   (cur_addr),
      .rd_data   (rd_data),
      .cfg_lsb   (cfg_lsb),
      .cfg_w4    (cfg_w4),
      .regs_flat (regs_flat)
   );

   spi_rf_txout u_tx (
      .sclk     (sclk),
      .csb      (csb),
      .rd_phase (rd_phase),
      .rd_data  (rd_data),
      .bit_pos  (bit_pos),
      .cfg_w4   (cfg_w4),
      .sdio_out (sdio_out),
      .sdio_oe  (sdio_oe),
      .sdo      (sdo),
      .sdo_oe   (sdo_oe)
   );
endmodule

// File: tb/sim_spi_reg_port.sv
module sim_spi_reg_port;
   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n, csb, sdio_in, sclk_en;
   logic sclk;
   logic sdio_out, sdio_oe, sdo, sdo_oe;
   logic [255:0] regs_flat;
   assign sclk = clk & sclk_en;

   spi_reg_port u0 (
      .rst_n(rst_n), .sclk(sclk), .csb(csb), .sdio_in(sdio_in),
      .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo(sdo), .sdo_oe(sdo_oe),
      .regs_flat(regs_flat)
   );

   int n_cmp = 0;
   int n_bad = 0;
   logic [7:0] model [32];
   bit m_lsb, m_w4;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int nbytes(input logic [1:0] code);
      return (code == 2'b00) ? 1 : (code == 2'b01) ? 3 : (code == 2'b10) ? 2 : 4;
   endfunction

   function automatic logic [255:0] model_flat();
      logic [255:0] f;
      for (int i = 0; i < 32; i++) f[i*8 +: 8] = model[i];
      return f;
   endfunction

   task automatic begin_frame();
      @(negedge clk);
      csb = 1'b0;
   endtask

   task automatic end_frame();
      @(negedge clk);
      sclk_en = 1'b0;
      #1 csb = 1'b1;
      @(negedge clk);
   endtask

   // one byte, bit order from the model; rd: this byte is read data
   task automatic xbyte(input logic [7:0] v, input bit rd, input int nbits,
                        output logic [7:0] got, output bit oe_ok);
      got = 8'h00;
      oe_ok = 1'b1;
      for (int k = 0; k < nbits; k++) begin
         int pos;
         pos = m_lsb ? k : 7 - k;
         @(negedge clk);
         sclk_en = 1'b1;
         sdio_in = v[pos];
         #1;
         got[pos] = m_w4 ? sdo : sdio_out;
         if (rd) oe_ok &= m_w4 ? (sdo_oe && !sdio_oe) : (sdio_oe && !sdo_oe);
         else    oe_ok &= !sdio_oe && !sdo_oe;
         @(posedge clk);
      end
   endtask

   task automatic do_write(input logic [1:0] n, input logic [4:0] a0, input logic [7:0] seed);
      logic [7:0] got, v;
      logic [4:0] a, nxt;
      bit ok;
      begin_frame();
      xbyte({1'b0, n, a0}, 1'b0, 8, got, ok);
      a = a0;
      for (int i = 0; i < nbytes(n); i++) begin
         v = seed + 8'(i * 8'h35);
         xbyte(v, 1'b0, 8, got, ok);
         nxt = m_lsb ? a + 5'd1 : a - 5'd1;       // R5 step uses order on the final bit
         model[a] = v;
         if (a == 5'd0) begin m_lsb = v[6]; m_w4 = v[7]; end
         #1 chk(regs_flat[a*8 +: 8] == v, "R4 write lands at last bit", regs_flat[a*8 +: 8], v);
         a = nxt;
      end
      xbyte(~seed, 1'b0, 8, got, ok);             // surplus byte must be ignored
      end_frame();
      chk(regs_flat == model_flat(), "R3/R5 bank after counted write", 0, 0);
   endtask

   task automatic do_read(input logic [1:0] n, input logic [4:0] a0);
      logic [7:0] got;
      logic [4:0] a;
      bit ok;
      begin_frame();
      xbyte({1'b1, n, a0}, 1'b0, 8, got, ok);
      chk(ok, "R9 no drive during command", ok, 1);
      a = a0;
      for (int i = 0; i < nbytes(n); i++) begin
         xbyte(8'h00, 1'b1, 8, got, ok);
         chk(got == model[a], "R8/R6 read data", got, model[a]);
         chk(ok, "R9 drive enable in read data phase", ok, 1);
         a = m_lsb ? a + 5'd1 : a - 5'd1;
      end
      xbyte(8'h00, 1'b0, 8, got, ok);
      chk(ok, "R9 enable drops after counted bytes", ok, 1);
      end_frame();
   endtask

   initial begin
      #600000;
      n_bad++;
      $display("FAIL watchdog R1 actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] got;
      bit ok;
      logic [4:0] addrs [5] = '{5'd0, 5'd1, 5'd17, 5'd30, 5'd31};
      rst_n = 1'b0; csb = 1'b1; sdio_in = 1'b0; sclk_en = 1'b0;
      for (int i = 0; i < 32; i++) model[i] = 8'h00;
      m_lsb = 1'b0; m_w4 = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(regs_flat == '0, "R1 reset bank", 0, 0);
      chk(!sdio_oe && !sdo_oe, "R1 enables low", {sdio_oe, sdo_oe}, 0);

      // R2/R3/R5/R6/R8/R9 sweep over mode, count code and start address
      for (int mode = 0; mode < 4; mode++) begin
         do_write(2'b00, 5'd0, {2'(mode), 6'h15});
         for (int n = 0; n < 4; n++)
            for (int j = 0; j < 5; j++) begin
               do_write(2'(n), addrs[j], 8'(mode * 64 + n * 16 + j * 3 + 1));
               do_read(2'(n), addrs[j]);
            end
      end

      // R7: order change written in byte one applies to byte two
      do_write(2'b00, 5'd0, 8'h00);
      do_write(2'b10, 5'd0, 8'h40);
      chk(regs_flat[31*8 +: 8] == 8'h75, "R7 second byte in new order", regs_flat[31*8 +: 8], 8'h75);
      chk(m_lsb == 1'b1, "R7 model order", m_lsb, 1);
      do_read(2'b00, 5'd31);
      do_write(2'b00, 5'd0, 8'h80);               // separate-pin mode, MSB first
      do_read(2'b11, 5'd3);

      // R10: abort mid data byte, then mid command
      do_write(2'b00, 5'd0, 8'h00);
      begin_frame();
      xbyte({1'b0, 2'b11, 5'd5}, 1'b0, 8, got, ok);
      xbyte(8'hC3, 1'b0, 8, got, ok);
      model[5] = 8'hC3;
      xbyte(8'h3C, 1'b0, 4, got, ok);
      end_frame();
      chk(regs_flat[5*8 +: 8] == 8'hC3, "R10 completed byte kept", regs_flat[5*8 +: 8], 8'hC3);
      chk(regs_flat[4*8 +: 8] == model[4], "R10 partial byte dropped", regs_flat[4*8 +: 8], model[4]);
      begin_frame();
      xbyte(8'hFF, 1'b0, 3, got, ok);
      end_frame();
      chk(regs_flat == model_flat(), "R10 partial command writes nothing", 0, 0);
      do_read(2'b00, 5'd5);
      do_write(2'b01, 5'd9, 8'h5A);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule